// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a parameterized number of hardware breakpoint slots for a 32-bit core. Software picks one slot through a select register. It then programs that slot through a configuration word and a compare word, both reached over a simple register-access port. Each slot takes one of two forms:

- **Address form.** The slot compares the instruction-fetch, load or store address against the compare word. The comparison is equal, unsigned greater-or-equal, or unsigned less-than.
- **Exception form.** The compare word is a bitmask of trap cause codes. A separate enable makes the slot fire on a non-maskable interrupt.

When any slot fires, the unit raises a request to enter debug mode in the same cycle. Because the request is combinational, the pipeline can act before the matched instruction executes. The configuration and compare words can be changed only while the core is in debug mode. Illegal field values written to the configuration word fall back to fixed legal values.

The select register is clamped to the last slot, so the selected slot always exists. Debug-mode sequencing around the request is left to the surrounding control logic.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, every slot reads configuration 0x6800_1044 (address form, equal mode, fetch matching on) and compare 0, and the select register reads 0. A slot in this state fires on a fetch of address 0.
- R2: Writing a value at or above NUM_TRIG to the select register (address 0x7A0) stores NUM_TRIG-1. Smaller values are stored as written. The select register can be written in any mode.
- R3: The configuration word (0x7A1) takes the exception form when the written type field [31:28] is 5, and the address form for any other value. Bit 27 always reads 1.
  - The address form reads {6, 1, zeros, action 1 at [15:12], mode at [10:7], bit 6 = 1, enables at [2:0]}.
  - The exception form reads {5, 1, zeros, NMI enable at [10], bit 9 = 1, action 1 at [5:0]}.
- R4: The address-form mode field [10:7] keeps the written values 0 (equal), 2 (greater-or-equal) and 3 (less-than). Any other written value is stored as 0.
- R5: Writes to the configuration word and the compare word (0x7A2) are ignored when the debug-mode input is low.
- R6: An address-form slot fires when a strobed address satisfies the mode against the compare word, using an unsigned 32-bit comparison. Fetch is gated by enable bit 2, store by bit 1 and load by bit 0.
- R7: An exception-form slot fires on a valid trap with cause code c when bit c of the compare word is set, provided the trap is not an NMI. On an NMI it fires exactly when configuration bit 10 is set.
- R8: The request output is the OR of all firing slots in the same cycle, and it is forced low while the debug-mode input is high.
- R9: Address 0x7A4 reads 0x60. Addresses 0x7A3, 0x7A5, 0x7A8 and 0x7AA, and any unmapped address, read 0.
- R10: With no fetch, load, store or trap strobe, the request output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data for csr_addr_i (combinational) |
| dbg_mode_i | input | 1 | Core is in debug mode |
| fetch_vld_i | input | 1 | Fetch address valid |
| fetch_addr_i | input | 32 | Instruction fetch address |
| load_vld_i | input | 1 | Load address valid |
| load_addr_i | input | 32 | Load address |
| store_vld_i | input | 1 | Store address valid |
| store_addr_i | input | 32 | Store address |
| trap_vld_i | input | 1 | Trap taken this cycle |
| trap_nmi_i | input | 1 | Trap is a non-maskable interrupt |
| trap_code_i | input | 5 | Trap cause code |
| halt_req_o | output | 1 | Debug-entry request |

## Verification
The hardest situation to reach is a request that comes from the right source while every other slot stays quiet. Every slot leaves reset armed on fetch address 0, so an unrelated slot can fire and mask the result under test.

The stimulus therefore enters debug mode and disarms the second slot before the vector table runs. Each vector reprograms slot 0 and then leaves debug mode before driving a single strobe.

Comparisons that straddle 0x8000_0000 separate unsigned from signed ordering. A write of mode 1 followed by an off-by-four fetch shows that the mode fell back to equality.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   localparam logic [11:0] A_SLOT_SEL = 12'h7A0;
   localparam logic [11:0] A_SLOT_CFG = 12'h7A1;
   localparam logic [11:0] A_SLOT_CMP = 12'h7A2;
   localparam logic [11:0] A_AUX_DATA = 12'h7A3;
   localparam logic [11:0] A_KIND_MAP = 12'h7A4;
   localparam logic [11:0] A_AUX_CTL  = 12'h7A5;
   localparam logic [11:0] A_CTX_HI   = 12'h7A8;
   localparam logic [11:0] A_CTX_LO   = 12'h7AA;

   localparam logic [3:0]  TYPE_EXC   = 4'd5;
   localparam logic [3:0]  TYPE_ADDR  = 4'd6;
   localparam logic [31:0] KIND_MAP_VAL = 32'h0000_0060;

   typedef enum logic {TK_ADDR = 1'b0, TK_EXC = 1'b1} trig_kind_e;

   // stored compare mode; value 1 is never stored
   localparam logic [1:0] CM_EQ = 2'd0;
   localparam logic [1:0] CM_GE = 2'd2;
   localparam logic [1:0] CM_LT = 2'd3;

   typedef struct packed {
      trig_kind_e kind;
      logic [1:0] mode;
      logic       exe_en;
      logic       st_en;
      logic       ld_en;
      logic       nmi_en;
   } trig_cfg_t;

   localparam trig_cfg_t CFG_RESET = '{kind: TK_ADDR, mode: CM_EQ, exe_en: 1'b1,
                                       st_en: 1'b0, ld_en: 1'b0, nmi_en: 1'b0};

   function automatic trig_cfg_t cfg_legalize(input logic [31:0] w);
      trig_cfg_t c;
      c.kind   = (w[31:28] == TYPE_EXC) ? TK_EXC : TK_ADDR;
      unique case (w[10:7])
         4'd2:    c.mode = CM_GE;
         4'd3:    c.mode = CM_LT;
         default: c.mode = CM_EQ;
      endcase
      c.exe_en = w[2];
      c.st_en  = w[1];
      c.ld_en  = w[0];
      c.nmi_en = w[10];
      return c;
   endfunction

   function automatic logic [31:0] cfg_render(input trig_cfg_t c);
      logic [31:0] r;
      if (c.kind == TK_EXC)
         r = {TYPE_EXC, 1'b1, 16'h0000, c.nmi_en, 1'b1, 3'b000, 6'd1};
      else
         r = {TYPE_ADDR, 1'b1, 11'h000, 4'd1, 1'b0, 2'b00, c.mode, 1'b1, 3'b000,
              c.exe_en, c.st_en, c.ld_en};
      return r;
   endfunction

endpackage

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] addr_i,
   input  logic [XLEN-1:0] ref_i,
   input  logic [1:0]      mode_i,
   output logic            hit_o
);
   import dbg_trig_pkg::*;

   always_comb begin
      unique case (mode_i)
         CM_GE:   hit_o = (addr_i >= ref_i);
         CM_LT:   hit_o = (addr_i <  ref_i);
         default: hit_o = (addr_i == ref_i);
      endcase
   end
endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot #(
   parameter int XLEN = 32
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     cfg_we_i,
   input  logic                     cmp_we_i,
   input  logic [XLEN-1:0]          wdata_i,
   input  logic                     fetch_vld_i,
   input  logic [XLEN-1:0]          fetch_addr_i,
   input  logic                     load_vld_i,
   input  logic [XLEN-1:0]          load_addr_i,
   input  logic                     store_vld_i,
   input  logic [XLEN-1:0]          store_addr_i,
   input  logic                     trap_vld_i,
   input  logic                     trap_nmi_i,
   input  logic [$clog2(XLEN)-1:0]  trap_code_i,
   output logic [31:0]              cfg_rd_o,
   output logic [XLEN-1:0]          cmp_rd_o,
   output logic                     fire_o
);
   import dbg_trig_pkg::*;

   localparam int NPORT = 3; // 0 fetch, 1 store, 2 load

   trig_cfg_t       cfg_q;
   logic [XLEN-1:0] cmp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= CFG_RESET;
         cmp_q <= '0;
      end else begin
         if (cfg_we_i) cfg_q <= cfg_legalize(wdata_i);
         if (cmp_we_i) cmp_q <= wdata_i;
      end
   end

   logic [XLEN-1:0] port_addr [NPORT];
   logic [NPORT-1:0] port_vld, port_en, port_hit;

   assign port_addr[0] = fetch_addr_i;
   assign port_addr[1] = store_addr_i;
   assign port_addr[2] = load_addr_i;
   assign port_vld     = {load_vld_i, store_vld_i, fetch_vld_i};
   assign port_en      = {cfg_q.ld_en, cfg_q.st_en, cfg_q.exe_en};

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      dbg_trig_cmp #(.XLEN(XLEN)) u_cmp (
         .addr_i (port_addr[p]),
         .ref_i  (cmp_q),
         .mode_i (cfg_q.mode),
         .hit_o  (port_hit[p])
      );
   end

   logic addr_fire, exc_fire;
   assign addr_fire = |(port_hit & port_vld & port_en);
   assign exc_fire  = trap_vld_i & (trap_nmi_i ? cfg_q.nmi_en : cmp_q[trap_code_i]);

   assign fire_o   = (cfg_q.kind == TK_EXC) ? exc_fire : addr_fire;
   assign cfg_rd_o = cfg_render(cfg_q);
   assign cmp_rd_o = cmp_q;
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit #(
   parameter int NUM_TRIG = 2,
   parameter int XLEN     = 32
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        csr_we_i,
   input  logic [11:0] csr_addr_i,
   input  logic [31:0] csr_wdata_i,
   output logic [31:0] csr_rdata_o,
   input  logic        dbg_mode_i,
   input  logic        fetch_vld_i,
   input  logic [31:0] fetch_addr_i,
   input  logic        load_vld_i,
   input  logic [31:0] load_addr_i,
   input  logic        store_vld_i,
   input  logic [31:0] store_addr_i,
   input  logic        trap_vld_i,
   input  logic        trap_nmi_i,
   input  logic [4:0]  trap_code_i,
   output logic        halt_req_o
);
   import dbg_trig_pkg::*;

   localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
   localparam logic [31:0] LAST_SLOT = 32'(NUM_TRIG - 1);

   if (NUM_TRIG < 1 || NUM_TRIG > 16) begin : g_bad_num
      $error("dbg_trig_unit: NUM_TRIG must be 1..16");
   end
   if (XLEN != 32) begin : g_bad_xlen
      $error("dbg_trig_unit: field layout needs XLEN == 32");
   end

   logic [SEL_W-1:0] sel_q;
   logic             wr_sel, wr_cfg, wr_cmp;

   assign wr_sel = csr_we_i && (csr_addr_i == A_SLOT_SEL);
   assign wr_cfg = csr_we_i && dbg_mode_i && (csr_addr_i == A_SLOT_CFG);
   assign wr_cmp = csr_we_i && dbg_mode_i && (csr_addr_i == A_SLOT_CMP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         sel_q <= '0;
      else if (wr_sel)
         sel_q <= (csr_wdata_i > LAST_SLOT) ? LAST_SLOT[SEL_W-1:0]
                                            : csr_wdata_i[SEL_W-1:0];
   end

   logic [31:0]   cfg_rd [NUM_TRIG];
   logic [31:0]   cmp_rd [NUM_TRIG];
   logic [NUM_TRIG-1:0] fire;

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_slot
      logic hit_sel;
      assign hit_sel = (sel_q == SEL_W'(t));
      dbg_trig_slot #(.XLEN(XLEN)) u_slot (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .cfg_we_i     (wr_cfg && hit_sel),
         .cmp_we_i     (wr_cmp && hit_sel),
         .wdata_i      (csr_wdata_i),
         .fetch_vld_i  (fetch_vld_i),
         .fetch_addr_i (fetch_addr_i),
         .load_vld_i   (load_vld_i),
         .load_addr_i  (load_addr_i),
         .store_vld_i  (store_vld_i),
         .store_addr_i (store_addr_i),
         .trap_vld_i   (trap_vld_i),
         .trap_nmi_i   (trap_nmi_i),
         .trap_code_i  (trap_code_i),
         .cfg_rd_o     (cfg_rd[t]),
         .cmp_rd_o     (cmp_rd[t]),
         .fire_o       (fire[t])
      );
   end

   assign halt_req_o = (|fire) && !dbg_mode_i;

   always_comb begin
      unique case (csr_addr_i)
         A_SLOT_SEL: csr_rdata_o = 32'(sel_q);
         A_SLOT_CFG: csr_rdata_o = cfg_rd[sel_q];
         A_SLOT_CMP: csr_rdata_o = cmp_rd[sel_q];
         A_KIND_MAP: csr_rdata_o = KIND_MAP_VAL;
         default:    csr_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk #(
   parameter int NUM_TRIG = 2
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic [11:0] csr_addr_i,
   input logic [31:0] csr_rdata_o,
   input logic        dbg_mode_i,
   input logic        fetch_vld_i,
   input logic        load_vld_i,
   input logic        store_vld_i,
   input logic        trap_vld_i,
   input logic        halt_req_o
);
   import dbg_trig_pkg::*;

   AST_SEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == A_SLOT_SEL) |-> (csr_rdata_o < 32'(NUM_TRIG))); // R2

   AST_CFG_TYPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == A_SLOT_CFG) |->
         (csr_rdata_o[27] && (csr_rdata_o[31:28] == TYPE_EXC || csr_rdata_o[31:28] == TYPE_ADDR))); // R3

   AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == A_SLOT_CFG && csr_rdata_o[31:28] == TYPE_ADDR) |->
         (csr_rdata_o[10:7] == 4'd0 || csr_rdata_o[10:7] == 4'd2 || csr_rdata_o[10:7] == 4'd3)); // R4

   AST_NO_HALT_IN_DEBUG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dbg_mode_i |-> !halt_req_o); // R8

   AST_KIND_MAP_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == A_KIND_MAP) |-> (csr_rdata_o == KIND_MAP_VAL)); // R9

   AST_NO_STROBE_NO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(fetch_vld_i || load_vld_i || store_vld_i || trap_vld_i) |-> !halt_req_o); // R10
endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(.NUM_TRIG(NUM_TRIG)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .csr_addr_i  (csr_addr_i),
   .csr_rdata_o (csr_rdata_o),
   .dbg_mode_i  (dbg_mode_i),
   .fetch_vld_i (fetch_vld_i),
   .load_vld_i  (load_vld_i),
   .store_vld_i (store_vld_i),
   .trap_vld_i  (trap_vld_i),
   .halt_req_o  (halt_req_o)
);

// File: tb/dbg_trig_unit_tb.sv
`timescale 1ns/1ps
module dbg_trig_unit_tb;

   localparam int NT = 2;
   localparam logic [11:0] SEL = 12'h7A0, CFG = 12'h7A1, CMP = 12'h7A2;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic        dbg = 1'b0;
   logic        fv = 1'b0, lv = 1'b0, sv = 1'b0, tv = 1'b0, tn = 1'b0;
   logic [31:0] fa = '0, la = '0, sa = '0;
   logic [4:0]  tc = '0;
   logic        halt;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dbg_trig_unit #(.NUM_TRIG(NT)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
      .csr_wdata_i(wdata), .csr_rdata_o(rdata), .dbg_mode_i(dbg),
      .fetch_vld_i(fv), .fetch_addr_i(fa), .load_vld_i(lv), .load_addr_i(la),
      .store_vld_i(sv), .store_addr_i(sa), .trap_vld_i(tv), .trap_nmi_i(tn),
      .trap_code_i(tc), .halt_req_o(halt));

   // port: 0 fetch, 1 load, 2 store
   typedef struct packed {
      logic [31:0] cfg;
      logic [31:0] cmp;
      logic [1:0]  port;
      logic [31:0] a;
      logic        exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{32'h6000_0004, 32'h0000_1000, 2'd0, 32'h0000_1000, 1'b1},
      '{32'h6000_0004, 32'h0000_1000, 2'd0, 32'h0000_1004, 1'b0},
      '{32'h6000_0104, 32'h8000_0000, 2'd0, 32'h8000_0000, 1'b1},
      '{32'h6000_0104, 32'h8000_0000, 2'd0, 32'h7FFF_FFFC, 1'b0},
      '{32'h6000_0184, 32'h8000_0000, 2'd0, 32'h7FFF_FFFC, 1'b1},
      '{32'h6000_0184, 32'h8000_0000, 2'd0, 32'hFFFF_FFFC, 1'b0},
      '{32'h6000_0001, 32'h0000_2000, 2'd1, 32'h0000_2000, 1'b1},
      '{32'h6000_0001, 32'h0000_2000, 2'd2, 32'h0000_2000, 1'b0},
      '{32'h6000_0002, 32'h0000_2000, 2'd2, 32'h0000_2000, 1'b1},
      '{32'h6000_0003, 32'h0000_2000, 2'd0, 32'h0000_2000, 1'b0},
      '{32'h6000_0084, 32'h0000_3000, 2'd0, 32'h0000_3000, 1'b1},
      '{32'h6000_0084, 32'h0000_3000, 2'd0, 32'h0000_3004, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #2;
      chk(req, rdata, exp);
   endtask

   task automatic strobe(input string req, input logic [1:0] port, input logic [31:0] a,
                         input logic exp);
      @(negedge clk);
      fv = (port == 2'd0); lv = (port == 2'd1); sv = (port == 2'd2);
      fa = a; la = a; sa = a;
      #2;
      chk(req, 32'(halt), 32'(exp));
      @(negedge clk);
      fv = 1'b0; lv = 1'b0; sv = 1'b0;
   endtask

   task automatic trap(input string req, input logic nmi, input logic [4:0] code,
                       input logic exp);
      @(negedge clk);
      tv = 1'b1; tn = nmi; tc = code;
      #2;
      chk(req, 32'(halt), 32'(exp));
      @(negedge clk);
      tv = 1'b0; tn = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd("R1 sel", SEL, 32'h0);
      rd("R1 cfg", CFG, 32'h6800_1044);
      rd("R1 cmp", CMP, 32'h0);
      // R10 no strobe
      @(negedge clk); #2; chk("R10 idle", 32'(halt), 32'h0);
      strobe("R1 reset slot fires at 0", 2'd0, 32'h0, 1'b1);

      // R9 fixed reads
      rd("R9 0x7A4", 12'h7A4, 32'h60);
      rd("R9 0x7A3", 12'h7A3, 32'h0);
      rd("R9 0x7A5", 12'h7A5, 32'h0);
      rd("R9 0x7A8", 12'h7A8, 32'h0);
      rd("R9 0x7AA", 12'h7AA, 32'h0);
      rd("R9 unmapped", 12'h300, 32'h0);

      // R2 select clamp
      wr(SEL, 32'd1);           rd("R2 sel 1", SEL, 32'd1);
      wr(SEL, 32'd7);           rd("R2 sel clamp", SEL, 32'd1);
      wr(SEL, 32'hFFFF_FFFF);   rd("R2 sel clamp max", SEL, 32'd1);

      // disarm slot 1 (in debug)
      dbg = 1'b1;
      wr(CFG, 32'h6000_0000);
      rd("R3 slot1 disarmed", CFG, 32'h6800_1040);
      wr(SEL, 32'd0);

      // R3 / R4 legalization
      wr(CFG, 32'h5000_0400);   rd("R3 exc form nmi", CFG, 32'h5800_0601);
      wr(CFG, 32'hF000_0000);   rd("R3 bad type", CFG, 32'h6800_1040);
      wr(CFG, 32'h6000_0184);   rd("R4 mode 3 kept", CFG, 32'h6800_11C4);
      wr(CFG, 32'h6000_0100);   rd("R4 mode 2 kept", CFG, 32'h6800_1140);
      wr(CFG, 32'h6000_0280);   rd("R4 mode 5 to 0", CFG, 32'h6800_1040);

      // R5 writes ignored outside debug
      wr(CMP, 32'h0000_ABCD);
      dbg = 1'b0;
      wr(CFG, 32'h5000_0400);   rd("R5 cfg held", CFG, 32'h6800_1040);
      wr(CMP, 32'h1234_5678);   rd("R5 cmp held", CMP, 32'h0000_ABCD);

      // R6 vector table on slot 0
      for (int i = 0; i < NV; i++) begin
         dbg = 1'b1;
         wr(CMP, VEC[i].cmp);
         wr(CFG, VEC[i].cfg);
         dbg = 1'b0;
         strobe($sformatf("R6 vector %0d", i), VEC[i].port, VEC[i].a, VEC[i].exp);
      end

      // R7 exception form
      dbg = 1'b1;
      wr(CMP, 32'h0000_0804);
      wr(CFG, 32'h5000_0000);
      dbg = 1'b0;
      trap("R7 code 11", 1'b0, 5'd11, 1'b1);
      trap("R7 code 2", 1'b0, 5'd2, 1'b1);
      trap("R7 code 3", 1'b0, 5'd3, 1'b0);
      trap("R7 nmi off", 1'b1, 5'd11, 1'b0);
      strobe("R7 exc ignores fetch", 2'd0, 32'h0000_0804, 1'b0);
      dbg = 1'b1;
      wr(CFG, 32'h5000_0400);
      dbg = 1'b0;
      trap("R7 nmi on", 1'b1, 5'd3, 1'b1);

      // R8 OR of slots and debug suppression
      dbg = 1'b1;
      wr(CMP, 32'h0000_0010);
      wr(CFG, 32'h6000_0001);
      wr(SEL, 32'd1);
      wr(CMP, 32'h0000_0020);
      wr(CFG, 32'h6000_0004);
      dbg = 1'b0;
      strobe("R8 slot1 fetch", 2'd0, 32'h0000_0020, 1'b1);
      strobe("R8 slot0 load", 2'd1, 32'h0000_0010, 1'b1);
      strobe("R8 neither", 2'd0, 32'h0000_0010, 1'b0);
      dbg = 1'b1;
      strobe("R8 suppressed in debug", 2'd0, 32'h0000_0020, 1'b0);
      dbg = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule